// File: doc/BRIEF.md
# DMA Command Sequence Decoder

This block sits on the command-plane write port of a flash controller. It watches every bus write, picks out those whose two map bits select the high-level command plane, and assembles the multi-write descriptors that software uses to start a page transfer through the DMA engine. Once the last word of a descriptor arrives, it raises one start pulse that carries every captured field: direction, bank, page, page count, burst length, completion-interrupt request and the full memory address. The same plane also carries a single-word block erase command, which the decoder turns into an erase pulse.

Two descriptor layouts are supported, chosen by a format input that is sampled on the first word. The wide layout takes three writes: a parameter word, then the low and the high halves of a 64-bit memory address. The narrow layout takes four writes and carries the 32-bit memory address in the bus address. Its later steps are tagged by marker values in the data word. A write that does not fit the step the decoder expects drops the partial descriptor, raises an error pulse and sends the decoder back to idle.

Top module: `dma_cmd_decoder`

## Requirements
- R1: After reset the start, erase and error pulses are all low and the decoder waits for a first descriptor word.
- R2: A write whose address bits [27:26] are not 2'b10 has no effect: it causes no pulse and does not disturb a descriptor that follows.
- R3: In idle, a command-plane write of data 32'h1 produces an erase pulse one cycle later. The pulse carries the bank from address bits [25:24] and the page from bits [23:0].
- R4: With the wide format selected, an idle write is a header when data[31:25]=0 and data[15:9]=7'b0010000. The header gives data[24] as the interrupt flag, data[23:16] as the burst length, data[8] as the direction (1 = write to flash) and data[7:0] as the page count. Bank and page are taken from the address.
- R5: In the wide format, the second write's data is memory address [31:0], and the third write's data is memory address [63:32]. The start pulse follows the third write by one cycle.
- R6: In the wide format, the second and third writes must carry the same bank and page as the header. Otherwise the error pulse fires and no start is issued.
- R7: With the narrow format selected, an idle write is a header when data[31:16]=0 and data[15:9]=7'b0010000, with data[8] as the direction and data[7:0] as the count. The page comes from that write's address, and the format is kept until the descriptor ends, whatever the format input does meanwhile.
- R8: In the narrow format, step 2 must carry data 32'h2200 and step 3 data 32'h2300. Their address bits [23:8] give memory address bits [31:16] and [15:0]. The upper 32 address bits of the start are zero.
- R9: In the narrow format, step 4 must carry data 32'h2400 with address bits [23:17] and [7:0] zero. Address bit 16 gives the interrupt flag and bits [15:8] give the burst length. The start pulse follows by one cycle.
- R10: Every descriptor word needs the DMA enable input high. A header or later step seen with it low produces an error pulse instead, and no start.
- R11: Any command-plane write that fits no expected step, including a bank change mid-descriptor, produces a one-cycle error pulse and returns the decoder to idle. The next write is decoded as a fresh first word.
- R12: Start, erase and error are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | 28 | Write address: map [27:26], bank [25:24], page or address field [23:0] |
| wr_data_i | input | 32 | Write data |
| dma_en_i | input | 1 | DMA enable flag |
| fmt64_i | input | 1 | 1 selects the three-write wide format, 0 the four-write narrow format |
| start_o | output | 1 | DMA start pulse |
| start_write_o | output | 1 | Direction: 1 moves memory to flash |
| start_bank_o | output | 2 | Bank of the transfer |
| start_page_o | output | 24 | Page address of the transfer |
| start_count_o | output | 8 | Page count |
| start_burst_o | output | 8 | Burst length in bytes |
| start_irq_o | output | 1 | Interrupt requested on completion |
| start_maddr_o | output | 64 | Memory address |
| erase_o | output | 1 | Erase pulse |
| erase_bank_o | output | 2 | Bank of the erase |
| erase_page_o | output | 24 | Page whose block is erased |
| err_o | output | 1 | Out-of-order or rejected word pulse |

## Verification
The hardest situations to reach are the ones where a descriptor is cut short partway through: a wrong marker at step 2, a stray address bit at step 4, the enable flag dropped just before the last word, or an erase word arriving where the narrow format expects a marker. The stimulus builds each of these from a correct prefix followed by one spoiled word, then runs a clean descriptor to show the decoder really went back to idle. Another case flips the format input in the middle of a narrow descriptor to show that the format chosen at the header is kept. Writes to other map planes are mixed in between descriptors to show that they leave no trace.

// File: rtl/dmadec_pkg.sv
package dmadec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_FIN  = 2'd3
  } dmadec_state_t;

  typedef struct packed {
    logic       ok;
    logic       write;
    logic       irq;
    logic [7:0] count;
    logic [7:0] burst;
  } dmadec_hdr_t;

  localparam logic [1:0]  CMD_PLANE  = 2'b10;
  localparam logic [31:0] ERASE_WORD = 32'h0000_0001;
  localparam logic [31:0] MARK_HI    = 32'h0000_2200;
  localparam logic [31:0] MARK_LO    = 32'h0000_2300;
  localparam logic [31:0] MARK_FIN   = 32'h0000_2400;
endpackage

// File: rtl/dmadec_addr_split.sv
module dmadec_addr_split #(
  parameter int PAGE_W = 24,
  parameter int BANK_W = 2,
  parameter int MAP_W  = 2,
  localparam int ADDR_W = MAP_W + BANK_W + PAGE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MAP_W-1:0]  map_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [PAGE_W-1:0] page_o
);
  assign map_o  = addr_i[ADDR_W-1 -: MAP_W];
  assign bank_o = addr_i[PAGE_W +: BANK_W];
  assign page_o = addr_i[PAGE_W-1:0];
endmodule

// File: rtl/dmadec_hdr_parse.sv
module dmadec_hdr_parse
  import dmadec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              fmt64_i,
  output logic              is_erase_o,
  output dmadec_hdr_t       hdr_o
);
  logic tag_ok;
  assign tag_ok     = (data_i[15:9] == 7'b0010000);
  assign is_erase_o = (data_i == DATA_W'(ERASE_WORD));

  always_comb begin
    hdr_o.write = data_i[8];
    hdr_o.count = data_i[7:0];
    if (fmt64_i) begin
      hdr_o.ok    = tag_ok && (data_i[DATA_W-1:25] == '0);
      hdr_o.irq   = data_i[24];
      hdr_o.burst = data_i[23:16];
    end else begin
      hdr_o.ok    = tag_ok && (data_i[DATA_W-1:16] == '0);
      hdr_o.irq   = 1'b0;
      hdr_o.burst = 8'd0;
    end
  end
endmodule

// File: rtl/dmadec_seq.sv
module dmadec_seq
  import dmadec_pkg::*;
#(
  parameter int PAGE_W  = 24,
  parameter int BANK_W  = 2,
  parameter int MAP_W   = 2,
  parameter int DATA_W  = 32,
  parameter int MADDR_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid_i,
  input  logic [MAP_W-1:0]   map_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [PAGE_W-1:0]  page_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               dma_en_i,
  input  logic               fmt64_i,
  input  logic               is_erase_i,
  input  dmadec_hdr_t        hdr_i,
  output logic               start_o,
  output logic               start_write_o,
  output logic [BANK_W-1:0]  start_bank_o,
  output logic [PAGE_W-1:0]  start_page_o,
  output logic [7:0]         start_count_o,
  output logic [7:0]         start_burst_o,
  output logic               start_irq_o,
  output logic [MADDR_W-1:0] start_maddr_o,
  output logic               erase_o,
  output logic [BANK_W-1:0]  erase_bank_o,
  output logic [PAGE_W-1:0]  erase_page_o,
  output logic               err_o
);
  localparam int HALF_W = MADDR_W / 2;
  localparam int SEG_W  = HALF_W / 2;

  dmadec_state_t      st_q, st_d;
  logic               fmt_q, fmt_d;
  logic               wr_q, wr_d, irq_q, irq_d;
  logic [BANK_W-1:0]  bank_q, bank_d;
  logic [PAGE_W-1:0]  page_q, page_d;
  logic [7:0]         cnt_q, cnt_d, burst_q, burst_d;
  logic [MADDR_W-1:0] maddr_q, maddr_d;
  logic               start_d, erase_d, err_d, cap_en, ers_en;
  logic               hit, step_ok;

  assign hit = wr_valid_i && (map_i == CMD_PLANE);

  always_comb begin
    st_d = st_q; fmt_d = fmt_q; wr_d = wr_q; irq_d = irq_q;
    bank_d = bank_q; page_d = page_q; cnt_d = cnt_q; burst_d = burst_q;
    maddr_d = maddr_q;
    start_d = 1'b0; erase_d = 1'b0; err_d = 1'b0; cap_en = 1'b0; ers_en = 1'b0;
    step_ok = 1'b0;
    if (hit) begin
      unique case (st_q)
        ST_IDLE: begin
          if (is_erase_i) begin
            erase_d = 1'b1; ers_en = 1'b1;
          end else if (hdr_i.ok && dma_en_i) begin
            cap_en = 1'b1; st_d = ST_LO;
            fmt_d = fmt64_i; wr_d = hdr_i.write; irq_d = hdr_i.irq;
            cnt_d = hdr_i.count; burst_d = hdr_i.burst;
            bank_d = bank_i; page_d = page_i; maddr_d = '0;
          end else begin
            err_d = 1'b1;
          end
        end
        ST_LO: begin
          step_ok = dma_en_i && (bank_i == bank_q) &&
                    (fmt_q ? (page_i == page_q) : (data_i == DATA_W'(MARK_HI)));
          if (step_ok) begin
            cap_en = 1'b1; st_d = ST_HI;
            if (fmt_q) maddr_d[HALF_W-1:0] = data_i[HALF_W-1:0];
            else       maddr_d[HALF_W-1:SEG_W] = page_i[23:8];
          end
        end
        ST_HI: begin
          step_ok = dma_en_i && (bank_i == bank_q) &&
                    (fmt_q ? (page_i == page_q) : (data_i == DATA_W'(MARK_LO)));
          if (step_ok) begin
            cap_en = 1'b1;
            if (fmt_q) begin
              maddr_d[MADDR_W-1:HALF_W] = data_i[HALF_W-1:0];
              start_d = 1'b1; st_d = ST_IDLE;
            end else begin
              maddr_d[SEG_W-1:0] = page_i[23:8];
              st_d = ST_FIN;
            end
          end
        end
        ST_FIN: begin
          step_ok = dma_en_i && (bank_i == bank_q) && (data_i == DATA_W'(MARK_FIN)) &&
                    (page_i[PAGE_W-1:17] == '0) && (page_i[7:0] == 8'd0);
          if (step_ok) begin
            cap_en = 1'b1; start_d = 1'b1; st_d = ST_IDLE;
            irq_d = page_i[16]; burst_d = page_i[15:8];
          end
        end
        default: st_d = ST_IDLE;
      endcase
      if (st_q != ST_IDLE && !step_ok) begin
        err_d = 1'b1; st_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      start_o <= 1'b0; erase_o <= 1'b0; err_o <= 1'b0;
      fmt_q <= 1'b0; wr_q <= 1'b0; irq_q <= 1'b0;
      bank_q <= '0; page_q <= '0; cnt_q <= '0; burst_q <= '0; maddr_q <= '0;
      erase_bank_o <= '0; erase_page_o <= '0;
    end else begin
      st_q    <= st_d;
      start_o <= start_d;
      erase_o <= erase_d;
      err_o   <= err_d;
      if (cap_en) begin
        fmt_q <= fmt_d; wr_q <= wr_d; irq_q <= irq_d;
        bank_q <= bank_d; page_q <= page_d; cnt_q <= cnt_d;
        burst_q <= burst_d; maddr_q <= maddr_d;
      end
      if (ers_en) begin
        erase_bank_o <= bank_i;
        erase_page_o <= page_i;
      end
    end
  end

  assign start_write_o = wr_q;
  assign start_bank_o  = bank_q;
  assign start_page_o  = page_q;
  assign start_count_o = cnt_q;
  assign start_burst_o = burst_q;
  assign start_irq_o   = irq_q;
  assign start_maddr_o = maddr_q;

  // R12: the three strobes never overlap
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, erase_o, err_o}));
  // R12: a start is never two cycles long
  a_r12_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  // R10: a start only follows a write seen with the enable flag high
  a_r10_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(dma_en_i) && $past(wr_valid_i));
  // R2: a write to another plane produces nothing
  a_r2_other_plane: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && map_i != CMD_PLANE) |=> !(start_o || erase_o || err_o));
  // R11: after an error the decoder is idle
  a_r11_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> st_q == ST_IDLE);
  // R3: erase is only reported for an idle-state write
  a_r3_erase_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    erase_o |-> $past(st_q) == ST_IDLE);
  // R8: narrow-format starts carry no upper address bits
  a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && !fmt_q) |-> start_maddr_o[MADDR_W-1:HALF_W] == '0);
endmodule

// File: rtl/dma_cmd_decoder.sv
module dma_cmd_decoder
  import dmadec_pkg::*;
#(
  parameter int PAGE_W  = 24,
  parameter int BANK_W  = 2,
  parameter int MAP_W   = 2,
  parameter int DATA_W  = 32,
  parameter int MADDR_W = 64,
  localparam int ADDR_W = MAP_W + BANK_W + PAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               dma_en_i,
  input  logic               fmt64_i,
  output logic               start_o,
  output logic               start_write_o,
  output logic [BANK_W-1:0]  start_bank_o,
  output logic [PAGE_W-1:0]  start_page_o,
  output logic [7:0]         start_count_o,
  output logic [7:0]         start_burst_o,
  output logic               start_irq_o,
  output logic [MADDR_W-1:0] start_maddr_o,
  output logic               erase_o,
  output logic [BANK_W-1:0]  erase_bank_o,
  output logic [PAGE_W-1:0]  erase_page_o,
  output logic               err_o
);
  logic [MAP_W-1:0]  map;
  logic [BANK_W-1:0] bank;
  logic [PAGE_W-1:0] page;
  logic              is_erase;
  dmadec_hdr_t       hdr;

  dmadec_addr_split #(.PAGE_W(PAGE_W), .BANK_W(BANK_W), .MAP_W(MAP_W)) u_split (
    .addr_i(wr_addr_i), .map_o(map), .bank_o(bank), .page_o(page));

  dmadec_hdr_parse #(.DATA_W(DATA_W)) u_parse (
    .data_i(wr_data_i), .fmt64_i(fmt64_i), .is_erase_o(is_erase), .hdr_o(hdr));

  dmadec_seq #(.PAGE_W(PAGE_W), .BANK_W(BANK_W), .MAP_W(MAP_W),
               .DATA_W(DATA_W), .MADDR_W(MADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i),
    .map_i(map), .bank_i(bank), .page_i(page), .data_i(wr_data_i),
    .dma_en_i(dma_en_i), .fmt64_i(fmt64_i), .is_erase_i(is_erase), .hdr_i(hdr),
    .start_o(start_o), .start_write_o(start_write_o), .start_bank_o(start_bank_o),
    .start_page_o(start_page_o), .start_count_o(start_count_o),
    .start_burst_o(start_burst_o), .start_irq_o(start_irq_o),
    .start_maddr_o(start_maddr_o), .erase_o(erase_o), .erase_bank_o(erase_bank_o),
    .erase_page_o(erase_page_o), .err_o(err_o));
endmodule

// File: tb/dma_cmd_decoder_bench.sv
module dma_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [27:0] wr_addr;
  logic [31:0] wr_data;
  logic        dma_en, fmt64;
  logic        start_o, start_write_o, start_irq_o, erase_o, err_o;
  logic [1:0]  start_bank_o, erase_bank_o;
  logic [23:0] start_page_o, erase_page_o;
  logic [7:0]  start_count_o, start_burst_o;
  logic [63:0] start_maddr_o;

  typedef struct packed {
    logic [1:0]  kind;   // 1 start, 2 erase, 3 error
    logic        write;
    logic [1:0]  bank;
    logic [23:0] page;
    logic [7:0]  count;
    logic [7:0]  burst;
    logic        irq;
    logic [63:0] maddr;
  } item_t;

  item_t expq[$];
  string tagq[$];
  int checks = 0, errors = 0, events = 0;
  logic mon_on = 1'b0;

  always #4 clk = ~clk;

  dma_cmd_decoder u_dma_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .dma_en_i(dma_en), .fmt64_i(fmt64),
    .start_o(start_o), .start_write_o(start_write_o), .start_bank_o(start_bank_o),
    .start_page_o(start_page_o), .start_count_o(start_count_o),
    .start_burst_o(start_burst_o), .start_irq_o(start_irq_o),
    .start_maddr_o(start_maddr_o), .erase_o(erase_o), .erase_bank_o(erase_bank_o),
    .erase_page_o(erase_page_o), .err_o(err_o));

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per strobe
  always @(negedge clk) begin
    if (mon_on && (start_o || erase_o || err_o)) begin
      item_t act;
      events++;
      act = '0;
      if (start_o) begin
        act.kind = 2'd1; act.write = start_write_o; act.bank = start_bank_o;
        act.page = start_page_o; act.count = start_count_o; act.burst = start_burst_o;
        act.irq = start_irq_o; act.maddr = start_maddr_o;
      end else if (erase_o) begin
        act.kind = 2'd2; act.bank = erase_bank_o; act.page = erase_page_o;
      end else act.kind = 2'd3;
      if ({start_o, erase_o, err_o} != 3'b100 && {start_o, erase_o, err_o} != 3'b010 &&
          {start_o, erase_o, err_o} != 3'b001)
        check("R12 strobes exclusive", 128'({start_o, erase_o, err_o}), 128'd0);
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected event actual kind=%0d expected none", act.kind);
      end else begin
        item_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s actual=%0h expected=%0h", t, act, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] map, input logic [1:0] bank,
                    input logic [23:0] pg, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = {map, bank, pg}; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic push(input string tag, input item_t it);
    expq.push_back(it); tagq.push_back(tag);
  endtask

  task automatic exp_err(input string tag);
    item_t it; it = '0; it.kind = 2'd3; push(tag, it);
  endtask

  task automatic desc64(input string tag, input logic [1:0] bank, input logic [23:0] pg,
                        input logic w, input logic [7:0] cnt, input logic [7:0] bl,
                        input logic irq, input logic [63:0] ma);
    item_t it;
    it = '0; it.kind = 2'd1; it.write = w; it.bank = bank; it.page = pg;
    it.count = cnt; it.burst = bl; it.irq = irq; it.maddr = ma;
    push(tag, it);
    fmt64 = 1'b1;
    wr(2'b10, bank, pg, {7'd0, irq, bl, 7'b0010000, w, cnt});
    wr(2'b10, bank, pg, ma[31:0]);
    wr(2'b10, bank, pg, ma[63:32]);
  endtask

  task automatic desc32(input string tag, input logic [1:0] bank, input logic [23:0] pg,
                        input logic w, input logic [7:0] cnt, input logic [7:0] bl,
                        input logic irq, input logic [31:0] ma);
    item_t it;
    it = '0; it.kind = 2'd1; it.write = w; it.bank = bank; it.page = pg;
    it.count = cnt; it.burst = bl; it.irq = irq; it.maddr = {32'd0, ma};
    push(tag, it);
    fmt64 = 1'b0;
    wr(2'b10, bank, pg, {16'd0, 7'b0010000, w, cnt});
    wr(2'b10, bank, {ma[31:16], 8'd0}, 32'h2200);
    wr(2'b10, bank, {ma[15:0], 8'd0}, 32'h2300);
    wr(2'b10, bank, {7'd0, irq, bl, 8'd0}, 32'h2400);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    check("queue drained", 128'(expq.size()), 128'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    item_t it;
    int ev0;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; dma_en = 1'b1; fmt64 = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pulses low in reset", 128'({start_o, erase_o, err_o}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pulses low after reset", 128'({start_o, erase_o, err_o}), 128'd0);
    mon_on = 1'b1;

    // R3: erase
    it = '0; it.kind = 2'd2; it.bank = 2'd1; it.page = 24'h00ABCD;
    push("R3 erase", it);
    wr(2'b10, 2'd1, 24'h00ABCD, 32'h1);
    drain();

    // R2: other planes ignored, then a clean descriptor
    ev0 = events;
    wr(2'b01, 2'd0, 24'h000010, 32'h1);
    wr(2'b11, 2'd2, 24'h000020, 32'h0100_2001);
    wr(2'b00, 2'd3, 24'h000030, 32'h0000_2005);
    repeat (2) @(negedge clk);
    check("R2 no event from other planes", 128'(events - ev0), 128'd0);
    desc64("R2 descriptor after ignored writes", 2'd0, 24'h000111, 1'b0, 8'd1, 8'd64,
           1'b1, 64'h0000_0001_0000_0000);
    drain();

    // R4 R5: wide format
    desc64("R4 R5 wide write", 2'd2, 24'h012345, 1'b1, 8'd1, 8'd64, 1'b1,
           64'hDEAD_BEEF_1234_5678);
    desc64("R4 R5 wide read", 2'd3, 24'hFFFFFF, 1'b0, 8'd3, 8'd32, 1'b0,
           64'h0000_0000_FFFF_FFF0);
    drain();

    // R7 R8 R9: narrow format
    desc32("R7 R8 R9 narrow", 2'd3, 24'h000777, 1'b0, 8'd2, 8'd64, 1'b1, 32'h89AB_CDEF);
    desc32("R9 narrow no irq", 2'd1, 24'h00F00D, 1'b1, 8'd255, 8'h20, 1'b0, 32'h0000_0040);
    drain();

    // R7: format latched at header
    it = '0; it.kind = 2'd1; it.bank = 2'd2; it.page = 24'h000042; it.count = 8'd4;
    it.burst = 8'd64; it.irq = 1'b1; it.maddr = 64'h0000_0000_1357_2468;
    push("R7 format latched", it);
    fmt64 = 1'b0;
    wr(2'b10, 2'd2, 24'h000042, 32'h0000_2004);
    fmt64 = 1'b1;
    wr(2'b10, 2'd2, 24'h135700, 32'h2200);
    wr(2'b10, 2'd2, 24'h246800, 32'h2300);
    wr(2'b10, 2'd2, 24'h014000, 32'h2400);
    drain();

    // R6: wide step with another page
    exp_err("R6 page mismatch");
    fmt64 = 1'b1;
    wr(2'b10, 2'd0, 24'h000100, 32'h0140_2001);
    wr(2'b10, 2'd0, 24'h000101, 32'h1111_2222);
    drain();

    // R11: bank change mid-descriptor, then fresh start works
    exp_err("R11 bank change");
    fmt64 = 1'b0;
    wr(2'b10, 2'd0, 24'h000100, 32'h0000_2001);
    wr(2'b10, 2'd1, 24'h123400, 32'h2200);
    desc32("R11 fresh after error", 2'd0, 24'h000100, 1'b0, 8'd1, 8'd64, 1'b1, 32'hCAFE_F00D);
    drain();

    // R8: wrong marker at step 2 (erase word)
    exp_err("R8 erase word as marker");
    fmt64 = 1'b0;
    wr(2'b10, 2'd3, 24'h000050, 32'h0000_2101);
    wr(2'b10, 2'd3, 24'h000050, 32'h1);
    drain();

    // R9: stray address bit at step 4
    exp_err("R9 stray step4 bit");
    wr(2'b10, 2'd1, 24'h000060, 32'h0000_2001);
    wr(2'b10, 2'd1, 24'h000100, 32'h2200);
    wr(2'b10, 2'd1, 24'h000200, 32'h2300);
    wr(2'b10, 2'd1, 24'h014001, 32'h2400);
    drain();

    // R10: enable low at header, and dropped before last word
    exp_err("R10 header without enable");
    dma_en = 1'b0; fmt64 = 1'b1;
    wr(2'b10, 2'd0, 24'h000070, 32'h0140_2001);
    dma_en = 1'b1;
    exp_err("R10 enable dropped at step 3");
    wr(2'b10, 2'd0, 24'h000070, 32'h0140_2001);
    wr(2'b10, 2'd0, 24'h000070, 32'h0000_1000);
    dma_en = 1'b0;
    wr(2'b10, 2'd0, 24'h000070, 32'h0000_0000);
    dma_en = 1'b1;
    drain();

    // R11: garbage in idle
    exp_err("R11 garbage idle word");
    wr(2'b10, 2'd2, 24'h000001, 32'h0000_5555);
    drain();

    // R12: pulse width, output low after event
    @(negedge clk);
    check("R12 strobes back low", 128'({start_o, erase_o, err_o}), 128'd0);

    mon_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule